// File: doc/BRIEF.md
# Maskable burst address counter

This block generates the internal word address for one port of a synchronous memory. It holds a loadable burst counter and a mask register of the same width. The counter can be loaded from an external address, stepped by one per clock, or partly cleared. The mask register decides which bits of the counter take part in counting. Set bits count. Clear bits keep the value they were loaded with. A burst therefore wraps inside a block of addresses that software chooses, and with the mask fully set it runs through the whole address space and rolls back to zero.

The same address input serves as the write data for the mask register whenever the mask-select input is high. A flag output tells the attached logic that an increment has just filled every counting bit with ones. This marks the last word of the current block. The readback bus returns either the counter or the mask, chosen by the mask-select input. Many blocks of this kind sit side by side, one for each port.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the counter is set to 0, the mask to all ones and `cnt_irq` to 0.
- R2: With `clr` low, `ld` high and `msk_sel` low, the counter takes `addr_in` at the edge. `mem_addr` shows the new value after that edge, and `cnt_irq` goes to 0.
- R3: With `clr`, `ld` and `msk_sel` low and `adv` high, the bits of the counter where the mask is 1 advance by one as a field and wrap to zero after all ones. The bits where the mask is 0 keep their value.
- R4: With `clr` high, the counter bits where the mask is 1 become 0 and the others keep their value, whatever `ld`, `adv` and `msk_sel` are. `cnt_irq` goes to 0 and the mask does not change.
- R5: When `ld` and `adv` are both high and `clr` is low, the load wins and no increment happens.
- R6: With `clr` low, `ld` high and `msk_sel` high, the mask takes `addr_in`, the counter keeps its value and `cnt_irq` goes to 0.
- R7: With `msk_sel` high, `adv` has no effect on the counter or on `cnt_irq`.
- R8: After an increment edge, `cnt_irq` is 1 if every counter bit under a set mask bit is now 1, and 0 otherwise. When no operation takes place it keeps its value.
- R9: `rb_data` equals the mask register while `msk_sel` is high and the counter while it is low, in the same cycle.
- R10: With the mask all ones, an increment from all ones gives address 0, and an increment that reaches all ones raises `cnt_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | AW | External address, or mask data when writing the mask |
| ld | input | 1 | Load strobe: counter load, or mask write when `msk_sel` is high |
| adv | input | 1 | Step the counter by one |
| clr | input | 1 | Clear the counting bits of the counter |
| msk_sel | input | 1 | Route load and readback to the mask register |
| mem_addr | output | AW | Registered internal memory address (the counter) |
| rb_data | output | AW | Readback of the counter or the mask |
| cnt_irq | output | 1 | Counting bits reached all ones on the last increment |

## Verification
Increments are tried with masks of several field widths: zero, a few bits, and all bits. The loaded addresses have random high bits, so a carry that leaks across the mask boundary shows up at once. Conflicting strobes are driven together (clear with load and step, load with step, step while the mask is selected) to separate the priority order from the plain actions. Random control mixes with only contiguous low masks are compared against a field-arithmetic model. Readback is checked before every edge, so a swapped select would show up.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [2:0] {
    OP_HOLD    = 3'd0,
    OP_CLR     = 3'd1,
    OP_LOAD    = 3'd2,
    OP_ADV     = 3'd3,
    OP_MASK_WR = 3'd4
  } bag_op_e;
endpackage

// File: rtl/bag_op_decode.sv
module bag_op_decode
  import burst_addr_pkg::*;
(
  input  logic    ld,
  input  logic    adv,
  input  logic    clr,
  input  logic    msk_sel,
  output bag_op_e op
);
  // clear beats load, load beats step; mask select steers load to the mask
  always_comb begin
    if (clr)                  op = OP_CLR;
    else if (ld && msk_sel)   op = OP_MASK_WR;
    else if (ld)              op = OP_LOAD;
    else if (adv && !msk_sel) op = OP_ADV;
    else                      op = OP_HOLD;
  end
endmodule

// File: rtl/bag_mask_reg.sv
module bag_mask_reg #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] mask
);
  localparam logic [AW-1:0] MASK_OPEN = {AW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)     mask <= MASK_OPEN;
    else if (wr) mask <= wdata;
  end

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wr) |-> mask == $past(wdata)); // R6
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !wr) |-> $stable(mask)); // R4
endmodule

// File: rtl/bag_counter.sv
module bag_counter
  import burst_addr_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  bag_op_e       op,
  input  logic [AW-1:0] addr_in,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] cnt,
  output logic          irq
);
  logic [AW-1:0] step_val;
  logic [AW-1:0] field_sum;
  logic          step_full;

  // fixed bits are forced to one so the carry skips over them
  always_comb begin
    field_sum = (cnt | ~mask) + {{(AW-1){1'b0}}, 1'b1};
    step_val  = (cnt & ~mask) | (field_sum & mask);
    step_full = (step_val & mask) == mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      unique case (op)
        OP_CLR: begin
          cnt <= cnt & ~mask;
          irq <= 1'b0;
        end
        OP_LOAD: begin
          cnt <= addr_in;
          irq <= 1'b0;
        end
        OP_ADV: begin
          cnt <= step_val;
          irq <= step_full;
        end
        OP_MASK_WR: irq <= 1'b0;
        default: ;
      endcase
    end
  end

  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && op == OP_LOAD) |-> cnt == $past(addr_in)); // R2
  AST_STEP_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && op == OP_ADV) |-> (cnt & ~$past(mask)) == ($past(cnt) & ~$past(mask))); // R3
  AST_CLR_FIELD_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && op == OP_CLR) |-> ((cnt & $past(mask)) == '0) &&
      ((cnt & ~$past(mask)) == ($past(cnt) & ~$past(mask)))); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && (op == OP_HOLD || op == OP_MASK_WR)) |-> $stable(cnt)); // R7
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_in,
  input  logic          ld,
  input  logic          adv,
  input  logic          clr,
  input  logic          msk_sel,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] rb_data,
  output logic          cnt_irq
);
  bag_op_e       op;
  logic [AW-1:0] mask;
  logic [AW-1:0] cnt;
  logic          irq;

  bag_op_decode u_dec (
    .ld      (ld),
    .adv     (adv),
    .clr     (clr),
    .msk_sel (msk_sel),
    .op      (op)
  );

  bag_mask_reg #(.AW(AW)) u_mask (
    .clk   (clk),
    .rst   (rst),
    .wr    (op == OP_MASK_WR),
    .wdata (addr_in),
    .mask  (mask)
  );

  bag_counter #(.AW(AW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .addr_in (addr_in),
    .mask    (mask),
    .cnt     (cnt),
    .irq     (irq)
  );

  assign mem_addr = cnt;
  assign cnt_irq  = irq;
  assign rb_data  = msk_sel ? mask : cnt;

  AST_IRQ_MEANS_FULL: assert property (@(posedge clk) disable iff (rst)
    cnt_irq |-> (mem_addr & mask) == mask); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> mem_addr == '0 && mask == {AW{1'b1}} && !cnt_irq); // R1
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
  localparam int AW = 17;
  localparam logic [AW-1:0] ONES = {AW{1'b1}};

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr_in;
  logic          ld, adv, clr, msk_sel;
  logic [AW-1:0] mem_addr, rb_data;
  logic          cnt_irq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [AW-1:0] m_cnt, m_mask;
  logic          m_irq;

  always #2 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .ld(ld), .adv(adv),
    .clr(clr), .msk_sel(msk_sel), .mem_addr(mem_addr), .rb_data(rb_data),
    .cnt_irq(cnt_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // contiguous low mask: the field is the low k bits
  function automatic logic [AW-1:0] low_mask(input int k);
    logic [31:0] w;
    w = (32'd1 << k) - 32'd1;
    return AW'(w);
  endfunction

  function automatic logic [AW-1:0] field_step(input logic [AW-1:0] c, input logic [AW-1:0] m);
    logic [AW-1:0] inc;
    inc = c + AW'(1);
    return (c & ~m) | (inc & m);
  endfunction

  task automatic model(input logic l, input logic a, input logic c, input logic s, input logic [AW-1:0] d);
    if (c) begin
      m_cnt = m_cnt & ~m_mask; m_irq = 1'b0;
    end else if (l && s) begin
      m_mask = d; m_irq = 1'b0;
    end else if (l) begin
      m_cnt = d; m_irq = 1'b0;
    end else if (a && !s) begin
      m_cnt = field_step(m_cnt, m_mask);
      m_irq = ((m_cnt & m_mask) == m_mask);
    end
  endtask

  task automatic step(input string req, input logic l, input logic a, input logic c,
                      input logic s, input logic [AW-1:0] d);
    ld = l; adv = a; clr = c; msk_sel = s; addr_in = d;
    #1;
    check({req, " R9 readback"}, 32'(rb_data), 32'(s ? m_mask : m_cnt));
    @(posedge clk);
    model(l, a, c, s, d);
    @(negedge clk);
    check({req, " addr"}, 32'(mem_addr), 32'(m_cnt));
    check({req, " irq"}, 32'(cnt_irq), 32'(m_irq));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; ld = 0; adv = 0; clr = 0; msk_sel = 0; addr_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_cnt = '0; m_mask = ONES; m_irq = 1'b0;
    // R1 reset state
    check("R1 addr", 32'(mem_addr), 32'd0);
    check("R1 irq", 32'(cnt_irq), 32'd0);
    msk_sel = 1'b1; #1;
    check("R1 mask", 32'(rb_data), 32'(ONES));

    // R10 full mask wrap
    step("R2 load", 1, 0, 0, 0, ONES - AW'(1));
    step("R10 reach ones", 0, 1, 0, 0, '0);
    check("R10 irq high", 32'(cnt_irq), 32'd1);
    step("R8 hold", 0, 0, 0, 0, '0);
    step("R10 wrap", 0, 1, 0, 0, '0);
    check("R10 zero", 32'(mem_addr), 32'd0);

    // R6 mask write, R3 block wrap
    step("R6 mask wr", 1, 0, 0, 1, low_mask(4));
    step("R2 load", 1, 0, 0, 0, AW'(17'h1234C));
    for (int i = 0; i < 5; i++) step("R3 block step", 0, 1, 0, 0, '0);
    check("R3 wrapped", 32'(mem_addr), 32'h12341);
    // R7 step ignored while mask selected
    step("R7 ignore", 0, 1, 0, 1, '0);
    // R4 clear beats load and step, also under mask select
    step("R4 clr prio", 1, 1, 1, 0, AW'(17'h0AAAA));
    check("R4 clr value", 32'(mem_addr), 32'h12340);
    step("R4 clr msk", 1, 1, 1, 1, AW'(17'h00F0F));
    // R5 load beats step
    step("R5 ld prio", 1, 1, 0, 0, AW'(17'h00777));
    check("R5 value", 32'(mem_addr), 32'h00777);
    // zero mask: nothing counts
    step("R6 zero mask", 1, 0, 0, 1, '0);
    step("R3 frozen", 0, 1, 0, 0, '0);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] d;
      int sel;
      sel = int'($urandom_range(0, 15));
      d = AW'($urandom);
      if (sel == 0) step("R6 rnd", 1, $urandom_range(0, 1) == 1, 0, 1,
                         low_mask(int'($urandom_range(0, AW))));
      else if (sel == 1) step("R4 rnd", $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                              1, $urandom_range(0, 1) == 1, d);
      else if (sel < 4) step("R2 rnd", 1, $urandom_range(0, 1) == 1, 0, 0, d);
      else if (sel == 4) step("R7 rnd", 0, 1, 0, 1, d);
      else if (sel == 5) step("R8 rnd", 0, 0, 0, 0, d);
      else step("R3 rnd", 0, 1, 0, 0, d);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule